// File: doc/BRIEF.md
# Shadowed Lockable Nonvolatile Store Controller

This block sits behind a serial command decoder and serves a byte-addressed register space that contains two 4-byte nonvolatile blocks. Each block is mirrored by a shadow RAM. Every byte read or write at a block address touches only the shadow copy. The nonvolatile array changes only when the host issues an explicit copy command. A recall command brings the array contents back into the shadow. The lock command makes a block permanently write-protected, but only when a write that arms it comes immediately before it. The nonvolatile array is modelled as registers, and a copy keeps the block busy for a programmable number of cycles.

The block also owns two registers. The store control register holds the busy flag, the arming bit and the two lock flags. The status register has three bits that are loaded from the second byte of block 1 whenever block 1 is recalled.

Requests arrive already decoded as an opcode, an address and write data, one per cycle. Opcodes: read=0, write=1, copy=2, recall=3, lock=4. An input tells the block whether the device is awake or asleep.

The block has two state machines:
- The copy engine has the states C_IDLE and C_RUN. Start moves it from C_IDLE to C_RUN. When the counter expires it moves from C_RUN back to C_IDLE and commits the shadow contents to the array.
- The lock arming machine has the states L_IDLE and L_ARMED. A write of 1 to bit 6 of 07h moves it from L_IDLE to L_ARMED. Any other request moves it back to L_IDLE.

Top module: `shadow_nv_ctrl`

## Requirements
- R1: After reset, every shadow and array byte is 00h, the status register at 01h reads 00h, and the control register at 07h reads 00h.
- R2: A write to 20h–23h (block 0) or 30h–33h (block 1) updates the shadow byte, and a read returns that byte. Reads of addresses the block does not own return 00h.
- R3: The block ignores writes to a locked block and writes to the read-only status register at 01h.
- R4: A copy of an unlocked block moves all four shadow bytes into the array. A later recall shows them.
- R5: Bit 7 of 07h (busy) reads 1 for exactly COPY_CYCLES cycles, starting in the cycle after the copy request. While it is 1, the block ignores writes and recalls at block addresses, but accesses to other addresses still proceed.
- R6: The block ignores a copy when the addressed block is locked, when the device is asleep, when a copy is already running, or when the address lies outside both blocks.
- R7: A recall loads the array into the shadow, even when the block is locked. A recall of block 1 also sets status bits 5, 4 and 3 from the same bits of byte 31h. The other status bits stay 0.
- R8: A lock takes effect only when the request just before it wrote 1 to bit 6 of 07h (the arming bit), and only when the device is awake. Otherwise it does nothing.
- R9: A lock that takes effect sets the block's flag (bit 0 for block 0, bit 1 for block 1 of 07h) and clears bit 6. The lock flags never clear again.
- R10: The result of a read appears on rd_data, with rd_valid high, in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| awake | input | 1 | 1 when the device is in active mode, 0 when asleep |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Opcode: 0 read, 1 write, 2 copy, 3 recall, 4 lock |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |

## Verification
The copy path is exercised three ways. A copy followed by a shadow overwrite and a recall shows that the array captured the earlier data. A copy issued while asleep, during another copy, or to a locked block leaves the array unchanged. Busy is read in the last cycle of the copy and in the cycle after it, which pins down its exact length.

The lock path is exercised three ways: with the arming write adjacent to the lock, with a read between them, and with the device asleep. The two failing cases distinguish a lock that needs strict adjacency from one that only checks the arming bit. The bench also recalls a locked block and then writes to it, which separates the recall path from write protection.

// File: rtl/snv_pkg.sv
package snv_pkg;
    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_COPY   = 3'd2,
        OP_RECALL = 3'd3,
        OP_LOCK   = 3'd4
    } snv_op_e;

    typedef enum logic {
        C_IDLE = 1'b0,
        C_RUN  = 1'b1
    } copy_state_e;

    typedef enum logic {
        L_IDLE  = 1'b0,
        L_ARMED = 1'b1
    } arm_state_e;
endpackage

// File: rtl/snv_copy_fsm.sv
module snv_copy_fsm
    import snv_pkg::*;
#(
    parameter int NBLK        = 2,
    parameter int COPY_CYCLES = 20,
    localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int CW = $clog2(COPY_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [BW-1:0]   blk_i,
    output logic            busy_o,
    output logic [NBLK-1:0] commit_o
);
    copy_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] blk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= C_IDLE;
            cnt_q   <= '0;
            blk_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == C_IDLE && start_i) begin
                cnt_q <= CW'(COPY_CYCLES - 1);
                blk_q <= blk_i;
            end else if (state_q == C_RUN && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        busy_o   = 1'b0;
        commit_o = '0;
        unique case (state_q)
            C_IDLE: if (start_i) state_d = C_RUN;
            C_RUN: begin
                busy_o = 1'b1;
                if (cnt_q == '0) begin
                    state_d         = C_IDLE;
                    commit_o[blk_q] = 1'b1;
                end
            end
            default: state_d = C_IDLE;
        endcase
    end

    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    p_commit_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|commit_o) |=> !busy_o);
    p_commit_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_o));
endmodule

// File: rtl/snv_lock_ctrl.sv
module snv_lock_ctrl
    import snv_pkg::*;
#(
    parameter int NBLK = 2,
    localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_any_i,
    input  logic            arm_wr_i,
    input  logic            arm_val_i,
    input  logic            lock_req_i,
    input  logic [BW-1:0]   lock_blk_i,
    output logic            lock_bit_o,
    output logic [NBLK-1:0] bl_o
);
    arm_state_e state_q, state_d;
    logic       fire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= L_IDLE;
            lock_bit_o <= 1'b0;
            bl_o       <= '0;
        end else begin
            state_q <= state_d;
            if (arm_wr_i) begin
                lock_bit_o <= arm_val_i;
            end else if (fire) begin
                lock_bit_o       <= 1'b0;
                bl_o[lock_blk_i] <= 1'b1;
            end
        end
    end

    // next state and fire decision
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            L_IDLE:  if (req_any_i && arm_wr_i && arm_val_i) state_d = L_ARMED;
            L_ARMED: begin
                fire = lock_req_i && lock_bit_o;
                if (req_any_i && !(arm_wr_i && arm_val_i)) state_d = L_IDLE;
            end
            default: state_d = L_IDLE;
        endcase
    end

    for (genvar b = 0; b < NBLK; b++) begin : g_chk
        p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            bl_o[b] |=> bl_o[b]);
        p_lock_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bl_o[b]) |-> $past(arm_wr_i && arm_val_i, 2));
    end
endmodule

// File: rtl/snv_store.sv
module snv_store #(
    parameter int NBLK  = 2,
    parameter int BYTES = 4,
    localparam int IW = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NBLK-1:0]                  wr_en_i,
    input  logic [IW-1:0]                    idx_i,
    input  logic [7:0]                       wdata_i,
    input  logic [NBLK-1:0]                  rcl_en_i,
    input  logic [NBLK-1:0]                  commit_i,
    input  logic [NBLK-1:0]                  locked_i,
    output logic [NBLK-1:0][BYTES-1:0][7:0]  shadow_o,
    output logic [NBLK-1:0][BYTES-1:0][7:0]  array_o
);
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_o[b] <= '0;
                array_o[b]  <= '0;
            end else begin
                if (commit_i[b]) array_o[b] <= shadow_o[b];
                if (rcl_en_i[b]) shadow_o[b] <= array_o[b];
                else if (wr_en_i[b]) shadow_o[b][idx_i] <= wdata_i;
            end
        end

        p_locked_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (locked_i[b] && !rcl_en_i[b]) |=> $stable(shadow_o[b]));
        p_array_copy_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !commit_i[b] |=> $stable(array_o[b]));
    end
endmodule

// File: rtl/shadow_nv_ctrl.sv
module shadow_nv_ctrl
    import snv_pkg::*;
#(
    parameter int               NBLK        = 2,
    parameter int               BYTES       = 4,
    parameter int               COPY_CYCLES = 20,
    parameter logic [1:0][7:0]  BLK_BASE    = {8'h30, 8'h20},
    parameter logic [7:0]       ADDR_STAT   = 8'h01,
    parameter logic [7:0]       ADDR_CTRL   = 8'h07,
    parameter logic [7:0]       STAT_MASK   = 8'h38,
    parameter int               STAT_BLK    = 1,
    parameter int               STAT_BYTE   = 1,
    localparam int IW = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       awake,
    input  logic       req_valid,
    input  logic [2:0] req_op,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       rd_valid,
    output logic [7:0] rd_data
);
    snv_op_e                         op;
    logic [NBLK-1:0]                 hit;
    logic                            is_nv;
    logic [BW-1:0]                   sel;
    logic [IW-1:0]                   idx;
    logic                            busy;
    logic                            lock_bit;
    logic [NBLK-1:0]                 bl;
    logic [NBLK-1:0]                 commit;
    logic [NBLK-1:0]                 wr_en, rcl_en;
    logic                            is_rd, is_wr, is_copy, is_rcl, is_lock;
    logic                            copy_start, lock_req, arm_wr;
    logic [7:0]                      status_q;
    logic [7:0]                      rd_mux;
    logic [NBLK-1:0][BYTES-1:0][7:0] shadow, array;

    assign op  = snv_op_e'(req_op);
    assign idx = req_addr[IW-1:0];

    for (genvar b = 0; b < NBLK; b++) begin : g_hit
        assign hit[b]    = (req_addr[7:IW] == BLK_BASE[b][7:IW]);
        assign wr_en[b]  = is_wr && hit[b] && !bl[b] && !busy;
        assign rcl_en[b] = is_rcl && hit[b] && !busy;
    end
    assign is_nv = |hit;

    always_comb begin
        sel = '0;
        for (int b = 0; b < NBLK; b++) if (hit[b]) sel = BW'(b);
    end

    assign is_rd   = req_valid && (op == OP_READ);
    assign is_wr   = req_valid && (op == OP_WRITE);
    assign is_copy = req_valid && (op == OP_COPY);
    assign is_rcl  = req_valid && (op == OP_RECALL);
    assign is_lock = req_valid && (op == OP_LOCK);

    assign copy_start = is_copy && is_nv && !bl[sel] && awake && !busy;
    assign lock_req   = is_lock && is_nv && awake;
    assign arm_wr     = is_wr && (req_addr == ADDR_CTRL);

    snv_copy_fsm #(.NBLK(NBLK), .COPY_CYCLES(COPY_CYCLES)) i_copy (
        .clk(clk), .rst_n(rst_n), .start_i(copy_start), .blk_i(sel),
        .busy_o(busy), .commit_o(commit)
    );

    snv_lock_ctrl #(.NBLK(NBLK)) i_lock (
        .clk(clk), .rst_n(rst_n), .req_any_i(req_valid), .arm_wr_i(arm_wr),
        .arm_val_i(req_wdata[6]), .lock_req_i(lock_req), .lock_blk_i(sel),
        .lock_bit_o(lock_bit), .bl_o(bl)
    );

    snv_store #(.NBLK(NBLK), .BYTES(BYTES)) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx),
        .wdata_i(req_wdata), .rcl_en_i(rcl_en), .commit_i(commit),
        .locked_i(bl), .shadow_o(shadow), .array_o(array)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else if (rcl_en[STAT_BLK]) status_q <= array[STAT_BLK][STAT_BYTE] & STAT_MASK;
    end

    always_comb begin
        rd_mux = '0;
        if (is_nv) begin
            rd_mux = shadow[sel][idx];
        end else if (req_addr == ADDR_STAT) begin
            rd_mux = status_q;
        end else if (req_addr == ADDR_CTRL) begin
            rd_mux      = '0;
            rd_mux[7]   = busy;
            rd_mux[6]   = lock_bit;
            rd_mux[NBLK-1:0] = bl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= is_rd;
            rd_data  <= is_rd ? rd_mux : 8'h00;
        end
    end

    p_busy_blocks_nv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (is_wr || is_rcl) && is_nv) |=> $stable(shadow));
    p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rd_valid);
    p_status_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~STAT_MASK) == 8'h00);
endmodule

// File: tb/test_shadow_nv_ctrl.sv
module test_shadow_nv_ctrl;
    localparam int CYC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       awake = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [7:0] req_addr = 8'h00;
    logic [7:0] req_wdata = 8'h00;
    logic       rd_valid;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    shadow_nv_ctrl #(.COPY_CYCLES(CYC)) i_shadow_nv_ctrl (
        .clk(clk), .rst_n(rst_n), .awake(awake), .req_valid(req_valid),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d); issue(3'd1, a, d); endtask
    task automatic cpy(input logic [7:0] a); issue(3'd2, a, 8'h00); endtask
    task automatic rcl(input logic [7:0] a); issue(3'd3, a, 8'h00); endtask
    task automatic lck(input logic [7:0] a); issue(3'd4, a, 8'h00); endtask
    task automatic idle(input int n); repeat (n) @(negedge clk); endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        issue(3'd0, a, 8'h00);
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #2;
        if (rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10: unexpected read result %02h, expected none", rd_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    fails++;
                    $display("FAIL %s: got %02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h07, 8'h00, "R1 ctrl reg");
        rd(8'h20, 8'h00, "R1 shadow");
        rd(8'h01, 8'h00, "R1 status");
        // R2 shadow access; R10 latency covered by every read
        wr(8'h20, 8'hA0); wr(8'h21, 8'hA1); wr(8'h22, 8'hA2); wr(8'h23, 8'hA3);
        wr(8'h31, 8'hFF);
        rd(8'h21, 8'hA1, "R2 block0 byte");
        rd(8'h31, 8'hFF, "R2 block1 byte");
        rd(8'h05, 8'h00, "R2 unowned addr");
        // R3 status read-only
        wr(8'h01, 8'hFF);
        rd(8'h01, 8'h00, "R3 status write ignored");
        // R5 busy and blocking
        cpy(8'h20);
        rd(8'h07, 8'h80, "R5 busy set");
        wr(8'h22, 8'h55);
        wr(8'h07, 8'h40);
        rd(8'h07, 8'hC0, "R5 other addr writable");
        wr(8'h07, 8'h00);
        idle(CYC + 2);
        rd(8'h07, 8'h00, "R5 busy cleared");
        rd(8'h22, 8'hA2, "R5 nv write during copy");
        // R4 copy then recall
        wr(8'h20, 8'h11);
        rcl(8'h20);
        rd(8'h20, 8'hA0, "R4 copied data recalled");
        // R5 exact length
        cpy(8'h30);
        idle(CYC - 1);
        rd(8'h07, 8'h80, "R5 last busy cycle");
        rd(8'h07, 8'h00, "R5 first idle cycle");
        // R7 status load
        wr(8'h31, 8'h00);
        rcl(8'h30);
        rd(8'h01, 8'h38, "R7 status from 31h");
        rd(8'h31, 8'hFF, "R7 block1 recalled");
        // R6 copy while asleep
        wr(8'h30, 8'h77);
        awake = 1'b0;
        cpy(8'h30);
        awake = 1'b1;
        idle(CYC + 2);
        wr(8'h30, 8'h66);
        rcl(8'h30);
        rd(8'h30, 8'h00, "R6 copy asleep ignored");
        // R6 copy while busy
        wr(8'h30, 8'h99);
        cpy(8'h20);
        cpy(8'h30);
        idle(CYC + 2);
        rcl(8'h30);
        rd(8'h30, 8'h00, "R6 copy during copy ignored");
        // R8 lock not adjacent
        wr(8'h07, 8'h40);
        rd(8'h07, 8'h40, "R8 arming bit set");
        lck(8'h20);
        rd(8'h07, 8'h40, "R8 non-adjacent lock ignored");
        // R8 lock asleep
        wr(8'h07, 8'h40);
        awake = 1'b0;
        lck(8'h20);
        awake = 1'b1;
        rd(8'h07, 8'h40, "R8 lock asleep ignored");
        // R9 proper lock of block 0 with shadow differing from array
        wr(8'h20, 8'h33);
        wr(8'h07, 8'h40);
        lck(8'h21);
        rd(8'h07, 8'h01, "R9 flag set, arm cleared");
        wr(8'h20, 8'h5A);
        rd(8'h20, 8'h33, "R3 locked write ignored");
        cpy(8'h20);
        rd(8'h07, 8'h01, "R6 locked copy ignored");
        rcl(8'h20);
        rd(8'h20, 8'hA0, "R7 recall of locked block");
        wr(8'h07, 8'h00);
        rd(8'h07, 8'h01, "R9 flag permanent");
        wr(8'h07, 8'h40);
        lck(8'h33);
        rd(8'h07, 8'h03, "R9 block1 flag");
        idle(4);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R10: %0d reads unanswered, expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule